// File: doc/BRIEF.md
# Word Memory with Full/Empty Tags

This block is a small synchronous memory in which each word owns a single tag bit marking it as full (holding data not yet consumed) or empty (free to be written). A producer port writes words and a consumer port reads them. Either port can issue a synchronized access, which depends on the tag, or a plain access, which ignores it. A synchronized write is accepted only into an empty word, and it marks the word full. A synchronized read is accepted only from a full word, and it marks the word empty. A refused synchronized access is answered with a retry in the same cycle, and the requester is expected to issue it again later.

Checking the tag, updating the tag and moving the data all happen together in a single clock cycle. No other access can fall between the check and the update. When both ports make synchronized accesses to the same word in one cycle, both are judged against the tag value held before that cycle. Exactly one of them is accepted. Responses and read data are combinational, and state changes take effect on the next rising clock edge.

Top module: `fe_word_mem`

## Requirements
- R1: Reset, asynchronous and active-low, marks every word empty, so a synchronized read of any address right after reset is answered with retry.
- R2: A synchronized write (`wr_mode`=1) to an empty word sets `wr_ok` in the same cycle, stores `wr_data` and marks the word full at the next clock edge.
- R3: A synchronized write to a full word sets `wr_retry` instead of `wr_ok` and leaves both the stored data and the tag unchanged.
- R4: A synchronized read (`rd_mode`=1) of a full word sets `rd_ok`, presents the stored word on `rd_data` in the same cycle and marks the word empty at the next clock edge.
- R5: A synchronized read of an empty word sets `rd_retry` instead of `rd_ok` and leaves the tag empty.
- R6: When a synchronized write and a synchronized read target the same address in one cycle, both are judged against the tag before that cycle: an empty word accepts the write and refuses the read, and a full word accepts the read (returning the old data) and refuses the write.
- R7: A plain write (`wr_mode`=0) always sets `wr_ok` and stores the data, but does not change the tag.
- R8: A plain read (`rd_mode`=0) always sets `rd_ok` and returns the stored word, whatever the tag, and does not change the tag.
- R9: On each port, ok and retry are never both high, exactly one of them is high while that port's request is high, and both are low when the request is low.
- R10: Accesses from the two ports to different addresses in one cycle are decided independently, each against its own word's tag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_req | input | 1 | Producer request |
| wr_mode | input | 1 | 1 = synchronized write, 0 = plain write |
| wr_addr | input | ADDR_W | Producer word address |
| wr_data | input | DATA_W | Data to store |
| wr_ok | output | 1 | Producer access accepted this cycle |
| wr_retry | output | 1 | Producer access refused, word is full |
| rd_req | input | 1 | Consumer request |
| rd_mode | input | 1 | 1 = synchronized read, 0 = plain read |
| rd_addr | input | ADDR_W | Consumer word address |
| rd_data | output | DATA_W | Stored word at rd_addr, before this cycle's write |
| rd_ok | output | 1 | Consumer access accepted this cycle |
| rd_retry | output | 1 | Consumer access refused, word is empty |

## Verification
The hardest case to produce is a synchronized write and a synchronized read hitting the same word in the same cycle, because the result depends on a tag value that cannot be seen at the ports. The stimulus table first puts the word into a known empty state and drives both accesses together. It then puts the word into a known full state and drives both accesses together again. After each collision, follow-up accesses check that only the accepted side changed the data and the tag. A tag that is left untouched by a plain access or by a refused access is revealed by the next synchronized access to that word.

// File: rtl/fe_mem_pkg.sv
package fe_mem_pkg;
   typedef enum logic {
      ACC_PLAIN = 1'b0,
      ACC_SYNC  = 1'b1
   } acc_mode_e;

   typedef struct packed {
      logic ok;
      logic retry;
   } resp_t;
endpackage

// File: rtl/fe_tag_array.sv
module fe_tag_array #(
   parameter int DEPTH  = 16,
   parameter int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_en,
   input  logic [ADDR_W-1:0] set_idx,
   input  logic              clr_en,
   input  logic [ADDR_W-1:0] clr_idx,
   output logic [DEPTH-1:0]  tags
);
   logic [DEPTH-1:0] tags_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tags_q <= '0;
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            if (set_en && (set_idx == ADDR_W'(i)))
               tags_q[i] <= 1'b1;
            else if (clr_en && (clr_idx == ADDR_W'(i)))
               tags_q[i] <= 1'b0;
         end
      end
   end

   assign tags = tags_q;

   // R1: after reset is released every tag reads empty
   p_reset_empty_r1: assert property (@(posedge clk)
      $rose(rst_n) |-> (tags_q == '0));

   // R2: a fill request marks its word full
   p_set_fills_r2: assert property (@(posedge clk) disable iff (!rst_n)
      set_en |=> tags_q[$past(set_idx)]);

   // R4: a drain request marks its word empty
   p_clr_empties_r4: assert property (@(posedge clk) disable iff (!rst_n)
      clr_en |=> !tags_q[$past(clr_idx)]);

   // R6: fill and drain never aim at one word together
   p_no_fill_drain_same_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (set_en && clr_en) |-> (set_idx != clr_idx));
endmodule

// File: rtl/fe_data_array.sv
module fe_data_array #(
   parameter int DEPTH      = 16,
   parameter int DATA_W     = 16,
   parameter bit RESET_DATA = 1'b1,
   parameter int ADDR_W     = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] mem [DEPTH];

   generate
      if (RESET_DATA) begin : g_clear
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (we) begin
               mem[waddr] <= wdata;
            end
         end
      end else begin : g_noclear
         always_ff @(posedge clk) begin
            if (we) mem[waddr] <= wdata;
         end
      end
   endgenerate

   assign rdata = mem[raddr];

   // R2: an accepted store is visible at the next edge
   p_store_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (mem[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/fe_sync_gate.sv
module fe_sync_gate
   import fe_mem_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int ADDR_W = $clog2(DEPTH)
) (
   input  logic [DEPTH-1:0]  tags,
   input  logic              wr_req,
   input  logic              wr_mode,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic              rd_req,
   input  logic              rd_mode,
   input  logic [ADDR_W-1:0] rd_addr,
   output resp_t             wr_resp,
   output resp_t             rd_resp,
   output logic              mem_we,
   output logic              tag_set,
   output logic              tag_clr
);
   logic wr_full, rd_full, wr_sync, rd_sync;

   always_comb begin
      wr_full = tags[wr_addr];
      rd_full = tags[rd_addr];
      wr_sync = wr_req && (acc_mode_e'(wr_mode) == ACC_SYNC);
      rd_sync = rd_req && (acc_mode_e'(rd_mode) == ACC_SYNC);

      wr_resp.retry = wr_sync && wr_full;
      wr_resp.ok    = wr_req && !wr_resp.retry;
      rd_resp.retry = rd_sync && !rd_full;
      rd_resp.ok    = rd_req && !rd_resp.retry;

      mem_we  = wr_resp.ok;
      tag_set = wr_sync && !wr_full;
      tag_clr = rd_sync && rd_full;
   end
endmodule

// File: rtl/fe_word_mem.sv
module fe_word_mem
   import fe_mem_pkg::*;
#(
   parameter int DEPTH      = 16,
   parameter int DATA_W     = 16,
   parameter bit RESET_DATA = 1'b1,
   localparam int ADDR_W    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_req,
   input  logic              wr_mode,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_ok,
   output logic              wr_retry,
   input  logic              rd_req,
   input  logic              rd_mode,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_ok,
   output logic              rd_retry
);
   generate
      if (DEPTH < 2 || (1 << ADDR_W) != DEPTH) begin : g_bad_depth
         $error("fe_word_mem: DEPTH must be a power of two of at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("fe_word_mem: DATA_W must be at least 1");
      end
   endgenerate

   logic [DEPTH-1:0] tags;
   resp_t            wr_resp, rd_resp;
   logic             mem_we, tag_set, tag_clr;

   fe_sync_gate #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_gate (
      .tags    (tags),
      .wr_req  (wr_req),
      .wr_mode (wr_mode),
      .wr_addr (wr_addr),
      .rd_req  (rd_req),
      .rd_mode (rd_mode),
      .rd_addr (rd_addr),
      .wr_resp (wr_resp),
      .rd_resp (rd_resp),
      .mem_we  (mem_we),
      .tag_set (tag_set),
      .tag_clr (tag_clr)
   );

   fe_tag_array #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_tags (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_en  (tag_set),
      .set_idx (wr_addr),
      .clr_en  (tag_clr),
      .clr_idx (rd_addr),
      .tags    (tags)
   );

   fe_data_array #(.DEPTH(DEPTH), .DATA_W(DATA_W), .RESET_DATA(RESET_DATA),
                   .ADDR_W(ADDR_W)) u_data (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (mem_we),
      .waddr (wr_addr),
      .wdata (wr_data),
      .raddr (rd_addr),
      .rdata (rd_data)
   );

   assign wr_ok    = wr_resp.ok;
   assign wr_retry = wr_resp.retry;
   assign rd_ok    = rd_resp.ok;
   assign rd_retry = rd_resp.retry;

   logic wr_sync_c, rd_sync_c, same_word;
   assign wr_sync_c = wr_req && wr_mode;
   assign rd_sync_c = rd_req && rd_mode;
   assign same_word = (wr_addr == rd_addr);

   // R9: exactly one response while requesting, none while idle
   p_wr_resp_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req |-> ($countones({wr_ok, wr_retry}) == 1));
   p_rd_resp_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> ($countones({rd_ok, rd_retry}) == 1));
   p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_req && !rd_req) |-> !(wr_ok || wr_retry || rd_ok || rd_retry));

   // R6: colliding synchronized accesses never both succeed
   p_collide_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_sync_c && rd_sync_c && same_word) |-> (wr_ok != rd_ok));

   // R3: a refused store keeps the word full
   p_wr_refuse_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_sync_c && wr_retry && !(rd_sync_c && same_word))
      |=> tags[$past(wr_addr)]);

   // R5: a refused fetch keeps the word empty
   p_rd_refuse_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_sync_c && rd_retry && !(wr_sync_c && same_word))
      |=> !tags[$past(rd_addr)]);

   // R7: a plain store leaves the tag where it was
   p_plain_wr_tag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && !wr_mode && !(rd_sync_c && same_word))
      |=> (tags[$past(wr_addr)] == $past(tags[wr_addr])));

   // R8: a plain fetch is always accepted
   p_plain_rd_ok_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !rd_mode) |-> rd_ok);
endmodule

// File: tb/fe_word_mem_bench.sv
module fe_word_mem_bench;
   localparam int DEPTH  = 16;
   localparam int DATA_W = 16;
   localparam int AW     = $clog2(DEPTH);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_req = 0, wr_mode = 0, rd_req = 0, rd_mode = 0;
   logic [AW-1:0] wr_addr = '0, rd_addr = '0;
   logic [DATA_W-1:0] wr_data = '0, rd_data;
   logic wr_ok, wr_retry, rd_ok, rd_retry;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #4 clk = ~clk;  // 125 MHz

   fe_word_mem #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fe_word_mem (
      .clk(clk), .rst_n(rst_n),
      .wr_req(wr_req), .wr_mode(wr_mode), .wr_addr(wr_addr), .wr_data(wr_data),
      .wr_ok(wr_ok), .wr_retry(wr_retry),
      .rd_req(rd_req), .rd_mode(rd_mode), .rd_addr(rd_addr), .rd_data(rd_data),
      .rd_ok(rd_ok), .rd_retry(rd_retry)
   );

   typedef struct packed {
      logic              wq;
      logic              wm;
      logic [3:0]        wa;
      logic [15:0]       wd;
      logic              rq;
      logic              rm;
      logic [3:0]        ra;
      logic [3:0]        resp;   // {wr_ok, wr_retry, rd_ok, rd_retry}
      logic              chk_d;
      logic [15:0]       ed;
      logic [7:0]        req;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t TBL [NV] = '{
      '{1'b1,1'b1,4'd3,16'hA5A5, 1'b0,1'b0,4'd0, 4'b1000, 1'b0,16'h0000, 8'd2},  // R2 fill a3
      '{1'b0,1'b0,4'd0,16'h0000, 1'b1,1'b1,4'd3, 4'b0010, 1'b1,16'hA5A5, 8'd4},  // R4 drain a3
      '{1'b0,1'b0,4'd0,16'h0000, 1'b1,1'b1,4'd3, 4'b0001, 1'b0,16'h0000, 8'd5},  // R5 empty refuse
      '{1'b1,1'b1,4'd3,16'h1111, 1'b1,1'b1,4'd3, 4'b1001, 1'b0,16'h0000, 8'd6},  // R6 collide on empty
      '{1'b1,1'b1,4'd3,16'h2222, 1'b1,1'b1,4'd3, 4'b0110, 1'b1,16'h1111, 8'd6},  // R6 collide on full
      '{1'b0,1'b0,4'd0,16'h0000, 1'b1,1'b1,4'd3, 4'b0001, 1'b0,16'h0000, 8'd5},  // R5 still empty
      '{1'b1,1'b0,4'd5,16'hBEEF, 1'b1,1'b0,4'd3, 4'b1010, 1'b1,16'h1111, 8'd8},  // R8 plain rd empty word
      '{1'b0,1'b0,4'd0,16'h0000, 1'b1,1'b1,4'd5, 4'b0001, 1'b0,16'h0000, 8'd7},  // R7 plain wr kept tag
      '{1'b1,1'b1,4'd5,16'h0001, 1'b1,1'b1,4'd3, 4'b1001, 1'b0,16'h0000, 8'd10}, // R10 independent
      '{1'b0,1'b0,4'd0,16'h0000, 1'b1,1'b0,4'd5, 4'b0010, 1'b1,16'h0001, 8'd8},  // R8 plain rd full
      '{1'b0,1'b0,4'd0,16'h0000, 1'b1,1'b1,4'd5, 4'b0010, 1'b1,16'h0001, 8'd8},  // R8 tag survived
      '{1'b1,1'b1,4'd7,16'h7777, 1'b1,1'b0,4'd7, 4'b1010, 1'b1,16'h0000, 8'd2},  // R2 old data seen
      '{1'b1,1'b1,4'd7,16'h8888, 1'b0,1'b0,4'd0, 4'b0100, 1'b0,16'h0000, 8'd3},  // R3 full refuse
      '{1'b0,1'b0,4'd0,16'h0000, 1'b1,1'b1,4'd7, 4'b0010, 1'b1,16'h7777, 8'd3}   // R3 data kept
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic wq, input logic wm, input logic [AW-1:0] wa,
                        input logic [DATA_W-1:0] wd, input logic rq, input logic rm,
                        input logic [AW-1:0] ra);
      @(negedge clk);
      wr_req = wq; wr_mode = wm; wr_addr = wa; wr_data = wd;
      rd_req = rq; rd_mode = rm; rd_addr = ra;
      #2;
   endtask

   initial begin
      #(8 * 100000);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: outputs idle during reset
      #2;
      check("R1 idle in reset", {wr_ok, wr_retry, rd_ok, rd_retry}, 0);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: every word empty after reset
      for (int a = 0; a < DEPTH; a++) begin
         drive(1'b0, 1'b0, '0, '0, 1'b1, 1'b1, AW'(a));
         check("R1 empty after reset", {rd_ok, rd_retry}, 2'b01);
      end

      for (int i = 0; i < NV; i++) begin
         drive(TBL[i].wq, TBL[i].wm, TBL[i].wa, TBL[i].wd,
               TBL[i].rq, TBL[i].rm, TBL[i].ra);
         check($sformatf("R%0d vec %0d resp", TBL[i].req, i),
               {wr_ok, wr_retry, rd_ok, rd_retry}, TBL[i].resp);
         if (TBL[i].chk_d)
            check($sformatf("R%0d vec %0d data", TBL[i].req, i), rd_data, TBL[i].ed);
      end

      // R9: idle ports give no response
      drive(1'b0, 1'b1, 4'd7, 16'h0, 1'b0, 1'b1, 4'd7);
      check("R9 idle", {wr_ok, wr_retry, rd_ok, rd_retry}, 0);

      // R1: reset mid-run empties a full word
      drive(1'b1, 1'b1, 4'd9, 16'h9999, 1'b0, 1'b0, '0);
      check("R2 fill a9", {wr_ok, wr_retry}, 2'b10);
      drive(1'b0, 1'b0, '0, '0, 1'b0, 1'b0, '0);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      drive(1'b0, 1'b0, '0, '0, 1'b1, 1'b1, 4'd9);
      check("R1 emptied by reset", {rd_ok, rd_retry}, 2'b01);
      // R2: a refill after reset is accepted
      drive(1'b1, 1'b1, 4'd9, 16'h4242, 1'b0, 1'b0, '0);
      check("R2 refill after reset", {wr_ok, wr_retry}, 2'b10);
      drive(1'b0, 1'b0, '0, '0, 1'b1, 1'b1, 4'd9);
      check("R4 drain after reset", {rd_ok, rd_retry}, 2'b10);
      check("R4 data after reset", rd_data, 16'h4242);

      drive(1'b0, 1'b0, '0, '0, 1'b0, 1'b0, '0);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule